// File: doc/BRIEF.md
# Debounced Manual Reset Qualifier

This block watches an asynchronous input on which an external switch signals a manual reset by driving it high. The input passes through a synchroniser. It is then sampled once per slow timer tick, nominally about 10 ms. A short high level is dropped as a glitch. A level that stays high for enough consecutive ticks is accepted as a reset request. The accepted request is reported on the level output `mrst_active`. The wake/watchdog controller uses this output to clear its counters, hold its wake output low and drive its reset output.

Once the request is accepted, the reset stays active while the switch is held. When the input goes low, the block requires a run of low samples before it treats the switch as released. A high sample in that window sends it back to the held condition. After the release is confirmed, the block emits a single-cycle `restart_cfg` pulse that restarts the startup configuration measurement. It then keeps `mrst_active` high for a reset-width tail of further ticks. While `mrst_active` is high, the controller does not run its startup measurement and does not configure a new interval.

Top module: `manual_reset_qualifier`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `mrst_active` and `restart_cfg` are both 0.
- R2: The input is resynchronised by two flops and read only on clock edges where `tick` is 1. The value read at such an edge is `mr_in` as captured two rising edges earlier.
- R3: `mrst_active` goes to 1 only after QUAL_TICKS (default 2) consecutive high samples. A run of fewer high samples is ignored and leaves both outputs at 0.
- R4: Both outputs are registered, and they change only on a clock edge where `tick` is 1.
- R5: Once `mrst_active` is 1, it stays 1 while the samples stay high. Release needs REL_TICKS (default 2) consecutive low samples.
- R6: A high sample before release is confirmed restarts the low-sample count from zero. The reset is never shortened by it.
- R7: On the tick that confirms release, `restart_cfg` is 1 for exactly one clock cycle, and `mrst_active` is still 1 in that cycle.
- R8: After release is confirmed, `mrst_active` stays 1 for TAIL_TICKS further low samples and falls on the last of them.
- R9: A high sample during the reset tail returns the block to the held condition. A new release confirmation is then needed, which issues `restart_cfg` again and starts a full tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle sample strobe from the slow oscillator divider |
| mr_in | input | 1 | Asynchronous manual reset input, active high |
| mrst_active | output | 1 | Qualified manual reset, held through release debounce and tail |
| restart_cfg | output | 1 | One-cycle pulse when release is confirmed |

## Verification
The hardest case to reach is a high sample that lands in the reset tail, after `restart_cfg` has already fired. A second case close to it is a single high sample inside the release debounce window. Both need the input to bounce at a chosen tick after a long hold. The stimulus therefore changes `mr_in` at known tick counts: a hold, a one-tick low, a re-press, and then a re-press a few ticks into the tail. Each point is placed so that it falls on a known sample. An edge-aligned pulse shorter than the tick spacing is also applied, to show that only the tick-edge value counts.

// File: rtl/manual_reset_qualifier.sv
module manual_reset_qualifier #(
  parameter int QUAL_TICKS = 2,
  parameter int REL_TICKS  = 2,
  parameter int TAIL_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mr_in,
  output logic mrst_active,
  output logic restart_cfg
);

  localparam int MAXC = (TAIL_TICKS > QUAL_TICKS) ?
                        ((TAIL_TICKS > REL_TICKS) ? TAIL_TICKS : REL_TICKS) :
                        ((QUAL_TICKS > REL_TICKS) ? QUAL_TICKS : REL_TICKS);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_QUAL, ST_HELD, ST_DEB, ST_TAIL} st_t;

  logic [1:0]    sync_q;
  logic          smp;
  st_t           st;
  logic [CW-1:0] cnt;
  logic          restart_q;

  assign smp = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], mr_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: if (smp) begin
            st  <= ST_QUAL;
            cnt <= CW'(1);
          end
          ST_QUAL: begin
            if (!smp) begin
              st  <= ST_IDLE;
              cnt <= '0;
            end else if (cnt == CW'(QUAL_TICKS - 1)) begin
              st  <= ST_HELD;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_HELD: if (!smp) begin
            st  <= ST_DEB;
            cnt <= CW'(1);
          end
          ST_DEB: begin
            if (smp) begin
              st  <= ST_HELD;
              cnt <= '0;
            end else if (cnt == CW'(REL_TICKS - 1)) begin
              st        <= ST_TAIL;
              cnt       <= '0;
              restart_q <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_TAIL: begin
            if (smp) begin
              st  <= ST_HELD;
              cnt <= '0;
            end else if (cnt == CW'(TAIL_TICKS - 1)) begin
              st  <= ST_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            st  <= ST_IDLE;
            cnt <= '0;
          end
        endcase
      end
    end
  end

  assign mrst_active = (st == ST_HELD) || (st == ST_DEB) || (st == ST_TAIL);
  assign restart_cfg = restart_q;

endmodule

// File: rtl/mrq_checker.sv
module mrq_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic mrst_active,
  input logic restart_cfg
);

  p_only_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(mrst_active) && !restart_cfg));

  p_restart_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_cfg |=> !restart_cfg);

  p_restart_in_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_cfg |-> mrst_active);

  p_no_fall_at_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_cfg |=> mrst_active);

  p_rise_without_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mrst_active) |-> !restart_cfg);

endmodule

bind manual_reset_qualifier mrq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick),
  .mrst_active(mrst_active), .restart_cfg(restart_cfg)
);

// File: tb/sim_manual_reset_qualifier.sv
module sim_manual_reset_qualifier;
  localparam int QUAL = 2;
  localparam int REL  = 2;
  localparam int TAIL = 5;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic mr_in = 1'b0;
  logic mrst_active, restart_cfg;

  always #4 clk = ~clk;

  manual_reset_qualifier #(.QUAL_TICKS(QUAL), .REL_TICKS(REL), .TAIL_TICKS(TAIL)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mr_in(mr_in),
    .mrst_active(mrst_active), .restart_cfg(restart_cfg)
  );

  int vectors = 0;
  int errs = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  int tdiv_cnt = 0;
  always @(negedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    tick <= rst_n && (tdiv_cnt == TDIV - 1);
  end

  bit d1, d2, smp;
  bit e_act, e_rst, in_tail;
  int hi_run, lo_run, tail_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 = 0; d2 = 0; e_act = 0; e_rst = 0; in_tail = 0;
      hi_run = 0; lo_run = 0; tail_n = 0;
    end else begin
      smp = d2;
      d2 = d1;
      d1 = mr_in;
      e_rst = 0;
      if (tick) begin
        if (!e_act) begin
          hi_run = smp ? hi_run + 1 : 0;
          if (hi_run == QUAL) begin
            e_act = 1; hi_run = 0; lo_run = 0; in_tail = 0;
          end
        end else if (smp) begin
          lo_run = 0; in_tail = 0;
        end else if (!in_tail) begin
          lo_run++;
          if (lo_run == REL) begin
            in_tail = 1; tail_n = 0; e_rst = 1;
          end
        end else begin
          tail_n++;
          if (tail_n == TAIL) begin
            e_act = 0; in_tail = 0; lo_run = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (mrst_active !== e_act) begin
        errs++;
        $display("FAIL %s mrst_active actual=%b expected=%b t=%0t", cur_req, mrst_active, e_act, $time);
      end
      if (restart_cfg !== e_rst) begin
        errs++;
        $display("FAIL %s restart_cfg actual=%b expected=%b t=%0t", cur_req, restart_cfg, e_rst, $time);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      finish_run();
    end
  end

  task automatic ticks(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    ticks(3);
    // R3 one-sample glitch ignored
    cur_req = "R3";
    mr_in = 1'b1; ticks(1); mr_in = 1'b0; ticks(4);
    // R2 sub-tick pulse
    cur_req = "R2";
    repeat (1) @(negedge clk);
    mr_in = 1'b1; repeat (2) @(negedge clk); mr_in = 1'b0;
    ticks(4);
    // R3 qualifying press, R5 long hold
    cur_req = "R3";
    mr_in = 1'b1; ticks(3);
    cur_req = "R5";
    ticks(5);
    // R6 bounce inside release debounce
    cur_req = "R6";
    mr_in = 1'b0; ticks(1);
    mr_in = 1'b1; ticks(2);
    // R7 release, R8 full tail
    cur_req = "R7";
    mr_in = 1'b0; ticks(3);
    cur_req = "R8";
    ticks(TAIL + 3);
    // R9 re-press inside the tail
    cur_req = "R9";
    mr_in = 1'b1; ticks(3);
    mr_in = 1'b0; ticks(REL + 2);
    mr_in = 1'b1; ticks(1);
    mr_in = 1'b0; ticks(REL + TAIL + 4);
    // R4 press with input edges between ticks
    cur_req = "R4";
    repeat (2) @(negedge clk);
    mr_in = 1'b1; ticks(4);
    mr_in = 1'b0; ticks(REL + TAIL + 3);
    // R1 reset mid-press
    cur_req = "R1";
    mr_in = 1'b1; ticks(3);
    rst_n = 1'b0; repeat (3) @(negedge clk);
    mr_in = 1'b0; rst_n = 1'b1;
    ticks(3);
    finish_run();
  end
endmodule